// File: doc/BRIEF.md
# Downward Stack Push/Pop Sequencer

This block owns a 16-bit stack pointer and moves two-byte words between a word-wide command interface and a byte-wide memory port. The stack grows toward lower addresses. A push stores one word as two byte writes. A pop fetches one word as two byte reads. The pointer is updated between the steps in a fixed order. Software can also load the pointer directly while the block is idle.

A command is sampled on a clock edge while the block is idle. The two memory steps then run in the next two cycles, one byte per cycle. `busy` is high for both step cycles, and `done` pulses in the second one. The memory is expected to return read data in the same cycle as the read strobe (asynchronous read). The fetched word appears on `pop_word` from the cycle after `done`.

Top module: `dstack_seq`

## Requirements
- R1: After reset, `sp_value` is 0x0000, `pop_word` is 0x0000, and `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: When `sp_load` is high in an idle cycle, `sp_value` equals `sp_new` from the next cycle on. A push or pop requested in the same cycle is dropped.
- R3: A push accepted with pointer value P performs two writes in the next two cycles. The first writes bits 15:8 of the word at P-1. The second writes bits 7:0 at P-2. The pointer then ends at P-2.
- R4: A pop accepted with pointer value P performs two reads in the next two cycles. The first reads the low byte at P. The second reads the high byte at P+1. The pointer then ends at P+2, and `pop_word` = {high, low} from the cycle after `done` until the next pop completes.
- R5: All pointer and address arithmetic wraps modulo 65536. A decrement from 0x0000 gives 0xFFFF, and an increment from 0xFFFF gives 0x0000.
- R6: `busy` is high in exactly the two step cycles of a push or pop. `done` is high only in the second of them.
- R7: `push_req`, `pop_req` and `sp_load` have no effect while `busy` is high.
- R8: If `push_req` and `pop_req` are both high in an idle cycle without `sp_load`, the push is performed and the pop is dropped.
- R9: `mem_rd` and `mem_wr` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request to push `push_word` |
| pop_req | input | 1 | Request to pop one word |
| push_word | input | 16 | Word to be pushed |
| sp_load | input | 1 | Load the pointer from `sp_new` |
| sp_new | input | 16 | New pointer value |
| sp_value | output | 16 | Current stack pointer |
| busy | output | 1 | A push or pop step is in progress |
| done | output | 1 | Final step cycle of a push or pop |
| pop_word | output | 16 | Last word fetched by a pop |
| mem_addr | output | 16 | Byte address of the current step |
| mem_rd | output | 1 | Byte read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte to be written |
| mem_rdata | input | 8 | Byte returned by memory in the read cycle |

## Verification
The embedded properties check several rules on every cycle. The strobes are exclusive and stay quiet when idle. `done` only occurs while busy. Each first step is followed by its partner step. Within a push the write address steps down by one, and within a pop the read address steps up by one. The pointer wraps correctly at both ends of its range. Other behaviours need the bench's scenarios to show them: the byte order on the bus, the words actually returned by pops, the priorities of load over commands and of push over pop, and the dropping of commands during a sequence. For these the bench's cycle reference model compares every output against its own memory image.

// File: rtl/dstack_pkg.sv
package dstack_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_PUSH_HI = 3'd1,
        SQ_PUSH_LO = 3'd2,
        SQ_POP_LO  = 3'd3,
        SQ_POP_HI  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_LOAD = 2'd1,
        PTR_DEC  = 2'd2,
        PTR_INC  = 2'd3
    } ptr_op_e;

endpackage

// File: rtl/dstack_ptr.sv
module dstack_ptr
    import dstack_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_op_e           op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] sp_dec
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] sp;
    } ptr_t;

    ptr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (op)
            PTR_LOAD: r_d.sp = load_val;
            PTR_DEC:  r_d.sp = r_q.sp - ONE;
            PTR_INC:  r_d.sp = r_q.sp + ONE;
            default:  r_d.sp = r_q.sp;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sp_q   = r_q.sp;
    assign sp_dec = r_q.sp - ONE;

    // R5: wrap at the bottom of the address range
    p_dec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PTR_DEC && sp_q == '0) |=> (&sp_q));

    // R5: wrap at the top of the address range
    p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PTR_INC && (&sp_q)) |=> (sp_q == '0));

endmodule

// File: rtl/dstack_ctrl.sv
module dstack_ctrl
    import dstack_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_req,
    input  logic                pop_req,
    input  logic                sp_load,
    input  logic [2*BYTE_W-1:0] push_word,
    input  logic [ADDR_W-1:0]   sp_q,
    input  logic [ADDR_W-1:0]   sp_dec,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output ptr_op_e             ptr_op,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                done,
    output logic [2*BYTE_W-1:0] pop_word
);

    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        seq_state_e         st;
        logic [WORD_W-1:0]  word;
        logic [BYTE_W-1:0]  lo;
        logic [WORD_W-1:0]  pop;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        ptr_op = PTR_HOLD;
        unique case (c_q.st)
            SQ_IDLE: begin
                if (sp_load) begin
                    ptr_op = PTR_LOAD;
                end else if (push_req) begin
                    c_d.st   = SQ_PUSH_HI;
                    c_d.word = push_word;
                end else if (pop_req) begin
                    c_d.st = SQ_POP_LO;
                end
            end
            SQ_PUSH_HI: begin
                ptr_op = PTR_DEC;
                c_d.st = SQ_PUSH_LO;
            end
            SQ_PUSH_LO: begin
                ptr_op = PTR_DEC;
                c_d.st = SQ_IDLE;
            end
            SQ_POP_LO: begin
                ptr_op = PTR_INC;
                c_d.lo = mem_rdata;
                c_d.st = SQ_POP_HI;
            end
            SQ_POP_HI: begin
                ptr_op  = PTR_INC;
                c_d.pop = {mem_rdata, c_q.lo};
                c_d.st  = SQ_IDLE;
            end
            default: c_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: SQ_IDLE, default: '0};
        else        c_q <= c_d;
    end

    always_comb begin
        mem_wr    = (c_q.st == SQ_PUSH_HI) || (c_q.st == SQ_PUSH_LO);
        mem_rd    = (c_q.st == SQ_POP_LO)  || (c_q.st == SQ_POP_HI);
        mem_addr  = mem_wr ? sp_dec : sp_q;
        mem_wdata = (c_q.st == SQ_PUSH_HI) ? c_q.word[WORD_W-1:BYTE_W]
                                           : c_q.word[BYTE_W-1:0];
        busy      = (c_q.st != SQ_IDLE);
        done      = (c_q.st == SQ_PUSH_LO) || (c_q.st == SQ_POP_HI);
    end

    assign pop_word = c_q.pop;

    // R3: high-byte write is always followed by the low-byte write
    p_push_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == SQ_PUSH_HI) |=> (c_q.st == SQ_PUSH_LO));

    // R4: low-byte read is always followed by the high-byte read
    p_pop_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == SQ_POP_LO) |=> (c_q.st == SQ_POP_HI));

    // R9: strobes exclusive
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: no strobe while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R6: completion only inside a sequence, and it ends the sequence
    p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/dstack_seq.sv
module dstack_seq
    import dstack_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_req,
    input  logic                pop_req,
    input  logic [2*BYTE_W-1:0] push_word,
    input  logic                sp_load,
    input  logic [ADDR_W-1:0]   sp_new,
    output logic [ADDR_W-1:0]   sp_value,
    output logic                busy,
    output logic                done,
    output logic [2*BYTE_W-1:0] pop_word,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata
);

    ptr_op_e           ptr_op;
    logic [ADDR_W-1:0] sp_dec;

    dstack_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (ptr_op),
        .load_val (sp_new),
        .sp_q     (sp_value),
        .sp_dec   (sp_dec)
    );

    dstack_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .sp_load   (sp_load),
        .push_word (push_word),
        .sp_q      (sp_value),
        .sp_dec    (sp_dec),
        .mem_rdata (mem_rdata),
        .ptr_op    (ptr_op),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .pop_word  (pop_word)
    );

    // R3: second push write lands one byte below the first
    p_wr_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !done) |=> (mem_wr && mem_addr == $past(mem_addr) - ADDR_W'(1)));

    // R4: second pop read lands one byte above the first
    p_rd_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !done) |=> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

endmodule

// File: tb/dstack_seq_bench.sv
`timescale 1ns/1ps
module dstack_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0, pop_req = 1'b0, sp_load = 1'b0;
    logic [15:0] push_word = '0, sp_new = '0;
    logic [15:0] sp_value, pop_word, mem_addr;
    logic        busy, done, mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    dstack_seq u_dstack_seq (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .push_word(push_word), .sp_load(sp_load), .sp_new(sp_new),
        .sp_value(sp_value), .busy(busy), .done(done), .pop_word(pop_word),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // byte memory seen by the block (low 8 address bits)
    logic [7:0] dev_mem [0:255];
    assign mem_rdata = dev_mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) dev_mem[mem_addr[7:0]] <= mem_wdata;

    // reference model
    logic [7:0]  ref_mem [0:255];
    int          ph;
    logic [15:0] m_sp, m_word, m_pop;
    logic [7:0]  m_lo;
    string       cur_req;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] e_addr;
        e_addr = (ph == 1 || ph == 2) ? m_sp - 16'd1 : m_sp;
        chk("R6", "busy", 16'(busy), 16'(ph != 0));
        chk("R6", "done", 16'(done), 16'(ph == 2 || ph == 4));
        chk("R3", "mem_wr", 16'(mem_wr), 16'(ph == 1 || ph == 2));
        chk("R4", "mem_rd", 16'(mem_rd), 16'(ph == 3 || ph == 4));
        chk("R9", "strobe_excl", 16'(mem_rd && mem_wr), 16'd0);
        if (ph == 1) chk("R3", "wdata_hi", 16'(mem_wdata), 16'(m_word[15:8]));
        if (ph == 2) chk("R3", "wdata_lo", 16'(mem_wdata), 16'(m_word[7:0]));
        if (ph != 0) chk((ph < 3) ? "R3" : "R4", "mem_addr", mem_addr, e_addr);
        chk(cur_req, "sp_value", sp_value, m_sp);
        chk(cur_req, "pop_word", pop_word, m_pop);
    endtask

    task automatic model_step(bit pu, bit po, bit ld, logic [15:0] ldv, logic [15:0] pv);
        case (ph)
            0: begin
                if (ld) m_sp = ldv;
                else if (pu) begin ph = 1; m_word = pv; end
                else if (po) ph = 3;
            end
            1: begin m_sp = m_sp - 16'd1; ref_mem[m_sp[7:0]] = m_word[15:8]; ph = 2; end
            2: begin m_sp = m_sp - 16'd1; ref_mem[m_sp[7:0]] = m_word[7:0];  ph = 0; end
            3: begin m_lo = ref_mem[m_sp[7:0]]; m_sp = m_sp + 16'd1; ph = 4; end
            default: begin m_pop = {ref_mem[m_sp[7:0]], m_lo}; m_sp = m_sp + 16'd1; ph = 0; end
        endcase
    endtask

    // inputs applied at negedge; compare; model advances past the posedge
    task automatic step(bit pu, bit po, bit ld, logic [15:0] ldv, logic [15:0] pv);
        push_req = pu; pop_req = po; sp_load = ld; sp_new = ldv; push_word = pv;
        #1;
        compare_all();
        @(posedge clk); #1;
        model_step(pu, po, ld, ldv, pv);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, 16'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        ph = 0; m_sp = '0; m_word = '0; m_pop = '0; m_lo = '0;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        // R1: reset values while held in reset
        chk("R1", "sp_value", sp_value, 16'h0000);
        chk("R1", "busy", 16'(busy), 16'd0);
        chk("R1", "done", 16'(done), 16'd0);
        chk("R1", "strobes", 16'({mem_rd, mem_wr}), 16'd0);
        chk("R1", "pop_word", pop_word, 16'h0000);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        step(0, 0, 1, 16'h1040, 16'h0);
        idle(1);

        cur_req = "R3";
        step(1, 0, 0, 16'h0, 16'hA1B2); idle(3);
        step(1, 0, 0, 16'h0, 16'hC3D4); idle(3);

        cur_req = "R4";
        step(0, 1, 0, 16'h0, 16'h0); idle(3);
        step(0, 1, 0, 16'h0, 16'h0); idle(3);
        step(0, 1, 0, 16'h0, 16'h0); idle(3);

        cur_req = "R7";
        step(1, 0, 0, 16'h0, 16'h1122);
        step(1, 1, 1, 16'h0200, 16'h3344);
        step(1, 1, 1, 16'h0300, 16'h5566);
        idle(2);
        step(0, 1, 0, 16'h0, 16'h0);
        step(1, 0, 1, 16'h0400, 16'h7788);
        step(0, 1, 0, 16'h0, 16'h0);
        idle(2);

        cur_req = "R8";
        step(1, 1, 0, 16'h0, 16'h99AA); idle(3);
        step(0, 1, 0, 16'h0, 16'h0); idle(3);

        cur_req = "R5";
        step(0, 0, 1, 16'h0001, 16'h0); idle(1);
        step(1, 0, 0, 16'h0, 16'hBEEF); idle(3);
        step(0, 1, 0, 16'h0, 16'h0); idle(3);
        step(0, 0, 1, 16'hFFFF, 16'h0); idle(1);
        step(0, 1, 0, 16'h0, 16'h0); idle(3);

        cur_req = "R2";
        step(1, 1, 1, 16'h0080, 16'h1357); idle(3);
        step(0, 0, 0, 16'h0, 16'h0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule